// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Port (Master/Slave)

This block is a synchronous serial port that either drives the bit clock itself (master) or follows a bit clock from outside (slave). Frames are 8 or 16 bits long and leave most-significant bit first. New bits shift in at the bottom of one shift register while outgoing bits are taken from its top. A host side with a write strobe and a read strobe feeds a transmit holding register and drains a receive holding register, so both directions are double-buffered. The host can queue the next word while the current frame is still on the wire, and it can read a finished word while the next one arrives.

In master mode, a write starts a frame at once. The bit clock is the system clock divided by four, then by a coarse divider chosen by a 2-bit code, then by a fine divider chosen by a 3-bit code. In slave mode, the external clock, select and data lines pass through two-flop synchronizers before edge detection. The external clock must therefore be much slower than the system clock. If a frame completes while the receive holding register is still unread, the block keeps the old word, flags an overflow and stops all shifting until the host reads.

Top module: `spi_port`

## Requirements
- R1: With `cfg_wide`=0 a frame is 8 bits. Bit 7 of the written word goes out first and bit 0 last. The received word appears in `rx_data[7:0]` with `rx_data[15:8]`=0. The upper byte of the written word is not sent.
- R2: With `cfg_wide`=1 a frame is 16 bits. Bit 15 goes out first and the received word fills all of `rx_data`.
- R3: When a frame completes and the receive register is free, `rx_data` takes the received word and `rx_full` goes to 1 on the same clock edge. A `host_rd` pulse returns `rx_full` to 0.
- R4: If a frame completes while `rx_full`=1 and no read is under way, `rx_ovf` goes to 1 and `rx_data` keeps its old value. All shifting stops and, in master mode, `sck_out` holds its level. This lasts until a `host_rd` pulse, which clears both `rx_ovf` and `rx_full`. The dropped word is never delivered.
- R5: A word written while a master frame is running is held. It starts as the next frame directly after the current one, with no idle half-period between the two.
- R6: In master mode a frame starts on the second clock edge after the write. Each bit takes two half-periods. `sck_out` is at the idle level (`cfg_idle_hi`) outside frames. With `cfg_tx_trail`=1 the first half of each bit is idle and the second active; with `cfg_tx_trail`=0 the first half is active and the second idle. Data is sampled on entry to the second half of each bit and changes on entry to the first half.
- R7: One half-period lasts 2·P·S system clocks. P is 64, 16, 4 or 1 for `cfg_pdiv` codes 0 to 3. S is 8 minus the `cfg_sdiv` code.
- R8: `irq` is a one-cycle pulse for each completed frame. In master mode it rises together with `rx_full`, one clock after the middle of the last bit. In slave mode it follows the sampling edge of the last bit.
- R9: In slave mode, bits are sampled and changed on edges of the synchronized `sck_in`. The edge sense follows `cfg_idle_hi` and `cfg_tx_trail` exactly as in master mode. A word written while no bit of a frame has yet been sampled drives `sdo` at once.
- R10: With `cfg_ss_en`=1 in slave mode, `sck_in` edges are ignored and `sdo_oe`=0 while `ss_n` is high.
- R11: `cfg_sdo_off`=1 forces `sdo_oe`=0 in every mode, while reception carries on.
- R12: A change of `cfg_wide` clears the holding registers, `rx_full`, `rx_ovf`, `irq` and any frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_wide | input | 1 | 1 = 16-bit frames, 0 = 8-bit frames |
| cfg_idle_hi | input | 1 | Idle level of the bit clock |
| cfg_tx_trail | input | 1 | 1 = data changes on active-to-idle, 0 = on idle-to-active |
| cfg_ss_en | input | 1 | Slave obeys `ss_n` when 1 |
| cfg_sdo_off | input | 1 | Releases `sdo` permanently when 1 |
| cfg_pdiv | input | 2 | Coarse divider code (64, 16, 4, 1) |
| cfg_sdiv | input | 3 | Fine divider code (8 down to 1) |
| host_wr | input | 1 | Write strobe for the transmit holding register |
| host_wdata | input | 16 | Word to transmit |
| host_rd | input | 1 | Read acknowledge for the receive holding register |
| rx_data | output | 16 | Receive holding register |
| sck_in | input | 1 | External bit clock (slave) |
| ss_n | input | 1 | Slave select, active low |
| sdi | input | 1 | Serial data in |
| sck_out | output | 1 | Bit clock (master) |
| sck_oe | output | 1 | Drive enable for `sck_out` |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| irq | output | 1 | Frame-complete pulse |
| rx_ovf | output | 1 | Receive overflow flag |
| rx_full | output | 1 | Receive holding register full |

## Verification
The master path runs with `sdo` looped back to `sdi`. The words are chosen so that the top and bottom bytes differ, which exposes a wrong frame width or a swapped byte, and a recorded bit stream tells MSB-first from LSB-first order. A clock-by-clock model of `sck_out` and `irq` is run across several divider codes, both idle levels, both edge choices and two frames sent back to back. This separates a wrong half-period, a wrong phase, a gap between queued frames and an interrupt placed at the wrong point in the frame. A second word is sent without reading the first, which must leave the old word in place, hold the clock and release it only after a read. In slave mode the bench drives its own clock and select: edges given while select is high must have no effect, and a full frame must move data both ways.

// File: rtl/spi_port.sv
module spi_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_master,
  input  logic        cfg_wide,
  input  logic        cfg_idle_hi,
  input  logic        cfg_tx_trail,
  input  logic        cfg_ss_en,
  input  logic        cfg_sdo_off,
  input  logic [1:0]  cfg_pdiv,
  input  logic [2:0]  cfg_sdiv,
  input  logic        host_wr,
  input  logic [15:0] host_wdata,
  input  logic        host_rd,
  output logic [15:0] rx_data,
  input  logic        sck_in,
  input  logic        ss_n,
  input  logic        sdi,
  output logic        sck_out,
  output logic        sck_oe,
  output logic        sdo,
  output logic        sdo_oe,
  output logic        irq,
  output logic        rx_ovf,
  output logic        rx_full
);
  logic        wide_q, busy, more, txf, full_q, ovf_q, irq_q, sdo_q;
  logic [15:0] sr, txb, rxb, shifted;
  logic [4:0]  cnt, hcnt;
  logic [10:0] div, half_len;
  logic [2:0]  sck_sy;
  logic [1:0]  ss_sy, sdi_sy;
  logic [3:0]  sec_ratio;
  logic [2:0]  shamt;
  logic        edge_seen, lead, trail, sel, s_go, tick, m_last, smp, chg, done;
  logic        msb_sr, msb_tx, msb_wr;

  assign sec_ratio = 4'd8 - {1'b0, cfg_sdiv};
  assign shamt     = {2'd3 - cfg_pdiv, 1'b0} + 3'd1;
  assign half_len  = {7'd0, sec_ratio} << shamt;

  assign edge_seen = sck_sy[1] ^ sck_sy[2];
  assign lead      = edge_seen && (sck_sy[1] != cfg_idle_hi);
  assign trail     = edge_seen && (sck_sy[1] == cfg_idle_hi);
  assign sel       = !cfg_ss_en || !ss_sy[1];
  assign s_go      = !cfg_master && !ovf_q && sel;

  assign tick   = cfg_master && busy && !ovf_q && (div >= half_len - 11'd1);
  assign m_last = hcnt == (wide_q ? 5'd31 : 5'd15);
  assign smp    = cfg_master ? (tick && !hcnt[0])
                             : (s_go && (cfg_tx_trail ? lead : trail));
  assign chg    = cfg_master ? (tick && hcnt[0] && (!m_last || more))
                             : (s_go && (cfg_tx_trail ? trail : lead));
  assign shifted = {sr[14:0], cfg_master ? sdi : sdi_sy[1]};
  assign done    = smp && (cnt == (wide_q ? 5'd15 : 5'd7));

  assign msb_sr = wide_q ? sr[15] : sr[7];
  assign msb_tx = wide_q ? txb[15] : txb[7];
  assign msb_wr = wide_q ? host_wdata[15] : host_wdata[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      ss_sy  <= 2'b11;
      sdi_sy <= '0;
    end else begin
      sck_sy <= {sck_sy[1:0], sck_in};
      ss_sy  <= {ss_sy[0], ss_n};
      sdi_sy <= {sdi_sy[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
      busy <= 1'b0; more <= 1'b0; txf <= 1'b0;
      full_q <= 1'b0; ovf_q <= 1'b0; irq_q <= 1'b0; sdo_q <= 1'b0;
      sr <= '0; txb <= '0; rxb <= '0;
      cnt <= '0; hcnt <= '0; div <= '0;
    end else if (cfg_wide != wide_q) begin
      wide_q <= cfg_wide;
      busy <= 1'b0; more <= 1'b0; txf <= 1'b0;
      full_q <= 1'b0; ovf_q <= 1'b0; irq_q <= 1'b0; sdo_q <= 1'b0;
      sr <= '0; txb <= '0; rxb <= '0;
      cnt <= '0; hcnt <= '0; div <= '0;
    end else begin
      irq_q <= done;
      if (host_rd) begin
        full_q <= 1'b0;
        ovf_q  <= 1'b0;
      end
      if (cfg_master && busy && !ovf_q)
        div <= tick ? 11'd0 : div + 11'd1;
      if (tick) begin
        if (m_last) begin
          hcnt <= '0;
          if (!more) busy <= 1'b0;
        end else begin
          hcnt <= hcnt + 5'd1;
        end
      end
      if (!cfg_master && cfg_ss_en && ss_sy[1]) cnt <= '0;
      if (smp) begin
        sr  <= shifted;
        cnt <= cnt + 5'd1;
      end
      if (chg) sdo_q <= msb_sr;
      if (done) begin
        cnt <= '0;
        if (full_q && !host_rd) ovf_q <= 1'b1;
        else begin
          rxb    <= wide_q ? shifted : {8'h00, shifted[7:0]};
          full_q <= 1'b1;
        end
        more <= txf;
        if (txf) begin
          sr  <= txb;
          txf <= 1'b0;
        end
      end
      if (cfg_master && !busy && txf) begin
        busy  <= 1'b1;
        more  <= 1'b0;
        hcnt  <= '0;
        div   <= '0;
        cnt   <= '0;
        sr    <= txb;
        sdo_q <= msb_tx;
        txf   <= 1'b0;
      end
      if (host_wr) begin
        if (!cfg_master && cnt == 5'd0 && !smp) begin
          sr    <= host_wdata;
          sdo_q <= msb_wr;
        end else begin
          txb <= host_wdata;
          txf <= 1'b1;
        end
      end
    end
  end

  assign sck_out = (cfg_master && busy)
                   ? (cfg_idle_hi ^ (cfg_tx_trail ? hcnt[0] : ~hcnt[0]))
                   : cfg_idle_hi;
  assign sck_oe  = cfg_master;
  assign sdo     = sdo_q;
  assign sdo_oe  = !cfg_sdo_off && (cfg_master || !cfg_ss_en || !ss_sy[1]);
  assign irq     = irq_q;
  assign rx_ovf  = ovf_q;
  assign rx_full = full_q;
  assign rx_data = rxb;
endmodule

module spi_port_props (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_master,
  input logic        cfg_wide,
  input logic        wide_q,
  input logic        host_rd,
  input logic        irq,
  input logic        rx_full,
  input logic        rx_ovf,
  input logic [15:0] rx_data,
  input logic        sck_out
);
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r3_irq_with_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_full || rx_ovf));

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && !host_rd && cfg_wide == wide_q) |=> rx_ovf);

  a_r4_rx_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf && cfg_wide == wide_q) |=> $stable(rx_data));

  a_r4_sck_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && rx_ovf && !host_rd && cfg_wide == wide_q) |=> $stable(sck_out));

  a_r12_width_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wide != wide_q) |=> (!rx_full && !rx_ovf && !irq));
endmodule

bind spi_port spi_port_props u_props (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_wide(cfg_wide),
  .wide_q(wide_q), .host_rd(host_rd), .irq(irq), .rx_full(rx_full),
  .rx_ovf(rx_ovf), .rx_data(rx_data), .sck_out(sck_out)
);

// File: tb/spi_port_test.sv
module spi_port_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_master, cfg_wide, cfg_idle_hi, cfg_tx_trail, cfg_ss_en, cfg_sdo_off;
  logic [1:0]  cfg_pdiv;
  logic [2:0]  cfg_sdiv;
  logic        host_wr, host_rd;
  logic [15:0] host_wdata;
  logic [15:0] rx_data;
  logic        sck_in, ss_n, sdi_drv, loop, sdi_w;
  logic        sck_out, sck_oe, sdo, sdo_oe, irq, rx_ovf, rx_full;

  int nchk = 0, nfail = 0, cyc = 0, irq_cnt = 0;
  int t0, mH, mN, mF, m, k, per, tot;
  logic mdl_on = 1'b0, m_idle, m_trail, es, ei;
  string mtag;
  logic [15:0] cap = '0;

  assign sdi_w = loop ? sdo : sdi_drv;

  spi_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_wide(cfg_wide),
    .cfg_idle_hi(cfg_idle_hi), .cfg_tx_trail(cfg_tx_trail), .cfg_ss_en(cfg_ss_en),
    .cfg_sdo_off(cfg_sdo_off), .cfg_pdiv(cfg_pdiv), .cfg_sdiv(cfg_sdiv),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .rx_data(rx_data),
    .sck_in(sck_in), .ss_n(ss_n), .sdi(sdi_w), .sck_out(sck_out), .sck_oe(sck_oe),
    .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq), .rx_ovf(rx_ovf), .rx_full(rx_full)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (irq) irq_cnt++;
  always @(posedge sck_out) cap <= {cap[14:0], sdo};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-clock reference for the master bit clock and the completion pulse
  always @(negedge clk) if (mdl_on) begin
    m = cyc - t0;
    per = 2 * mN * mH;
    tot = mF * per;
    if (m >= 1 && m <= tot) begin
      k  = ((m - 1) / mH) % (2 * mN);
      es = m_idle ^ (m_trail ? k[0] : ~k[0]);
      ei = ((m - 1) % per) == (2 * mN - 1) * mH;
    end else begin
      es = m_idle;
      ei = 1'b0;
    end
    chk(mtag, {31'd0, sck_out}, {31'd0, es});
    chk("R8", {31'd0, irq}, {31'd0, ei});
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_tx(input logic [15:0] d);
    @(negedge clk);
    host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic start_master(input logic [15:0] d, input int h, input int n,
                              input int f, input string tag);
    @(negedge clk);
    t0 = cyc + 1; mH = h; mN = n; mF = f; mtag = tag;
    m_idle = cfg_idle_hi; m_trail = cfg_tx_trail;
    mdl_on = 1'b1;
    host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic read_rx;
    @(negedge clk);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic       frz;
    int         i0;
    rst_n = 1'b0; cfg_master = 1'b1; cfg_wide = 1'b0; cfg_idle_hi = 1'b0;
    cfg_tx_trail = 1'b1; cfg_ss_en = 1'b0; cfg_sdo_off = 1'b0;
    cfg_pdiv = 2'd3; cfg_sdiv = 3'd6; host_wr = 1'b0; host_rd = 1'b0;
    host_wdata = '0; sck_in = 1'b0; ss_n = 1'b1; sdi_drv = 1'b0; loop = 1'b1;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    chk("R3 reset full", {31'd0, rx_full}, 0);
    chk("R4 reset ovf", {31'd0, rx_ovf}, 0);
    chk("R6 reset sck", {31'd0, sck_out}, 0);
    chk("R8 reset irq", {31'd0, irq}, 0);

    // R1, R6: 8-bit loopback, half period 4 clocks
    start_master(16'h12A5, 4, 8, 1, "R6");
    wait_n(2 * 8 * 4 + 6);
    mdl_on = 1'b0;
    chk("R1 rx low byte", {16'd0, rx_data}, 32'h00A5);
    chk("R1 msb first", {24'd0, cap[7:0]}, 32'hA5);
    chk("R3 full set", {31'd0, rx_full}, 1);

    // R12: width change wipes buffers and flags
    @(negedge clk);
    cfg_wide = 1'b1; cfg_idle_hi = 1'b1; cfg_tx_trail = 1'b0; cfg_sdiv = 3'd7;
    wait_n(2);
    chk("R12 full cleared", {31'd0, rx_full}, 0);
    chk("R12 rx cleared", {16'd0, rx_data}, 0);

    // R2, R5: two 16-bit frames back to back, half period 2
    start_master(16'h1234, 2, 16, 2, "R5");
    wait_n(3);
    write_tx(16'hBEEF);
    do @(negedge clk); while (!irq);
    chk("R2 first word", {16'd0, rx_data}, 32'h1234);
    read_rx();
    chk("R3 read clears", {31'd0, rx_full}, 0);
    while (cyc < t0 + 2 * 2 * 32 * 2 + 4) @(negedge clk);
    mdl_on = 1'b0;
    chk("R5 second word", {16'd0, rx_data}, 32'hBEEF);
    chk("R5 no ovf", {31'd0, rx_ovf}, 0);
    read_rx();

    // R4: overflow freezes the master
    @(negedge clk);
    cfg_wide = 1'b0; cfg_idle_hi = 1'b0; cfg_tx_trail = 1'b1; cfg_sdiv = 3'd6;
    wait_n(2);
    write_tx(16'h003C);
    wait_n(2 * 8 * 4 + 6);
    write_tx(16'h00C3);
    wait_n(2 * 8 * 4 + 6);
    chk("R4 ovf set", {31'd0, rx_ovf}, 1);
    chk("R4 old word kept", {16'd0, rx_data}, 32'h003C);
    chk("R4 sck held active", {31'd0, sck_out}, 1);
    frz = sck_out;
    wait_n(40);
    chk("R4 sck still held", {31'd0, sck_out}, {31'd0, frz});
    read_rx();
    chk("R4 ovf cleared", {31'd0, rx_ovf}, 0);
    chk("R4 full cleared", {31'd0, rx_full}, 0);
    wait_n(10);
    chk("R4 frame released", {31'd0, sck_out}, 0);
    chk("R4 dropped word", {16'd0, rx_data}, 32'h003C);

    // R7: slower divider codes, half period 2*4*3 = 24
    @(negedge clk);
    cfg_pdiv = 2'd2; cfg_sdiv = 3'd5;
    start_master(16'h005A, 24, 8, 1, "R7");
    wait_n(2 * 8 * 24 + 6);
    mdl_on = 1'b0;
    chk("R7 data", {16'd0, rx_data}, 32'h005A);
    read_rx();

    // R11: output released, reception continues
    @(negedge clk);
    cfg_pdiv = 2'd3; cfg_sdiv = 3'd6; cfg_sdo_off = 1'b1; loop = 1'b0; sdi_drv = 1'b1;
    wait_n(1);
    chk("R11 oe low", {31'd0, sdo_oe}, 0);
    write_tx(16'h0000);
    wait_n(2 * 8 * 4 + 6);
    chk("R11 receive", {16'd0, rx_data}, 32'h00FF);
    read_rx();
    @(negedge clk);
    cfg_sdo_off = 1'b0;

    // R10, R9: slave with select enabled
    @(negedge clk);
    cfg_master = 1'b0; cfg_ss_en = 1'b1; ss_n = 1'b1; sdi_drv = 1'b1;
    wait_n(4);
    chk("R10 oe low when deselected", {31'd0, sdo_oe}, 0);
    write_tx(16'h0096);
    for (int b = 0; b < 8; b++) begin
      wait_n(6); sck_in = 1'b1;
      wait_n(6); sck_in = 1'b0;
    end
    wait_n(8);
    chk("R10 edges ignored", {31'd0, rx_full}, 0);
    chk("R10 no ovf", {31'd0, rx_ovf}, 0);
    @(negedge clk);
    ss_n = 1'b0;
    wait_n(4);
    chk("R10 oe high when selected", {31'd0, sdo_oe}, 1);
    i0 = irq_cnt;
    got = '0;
    for (int b = 7; b >= 0; b--) begin
      sdi_drv = (8'h5A >> b) & 8'h01;
      wait_n(6);
      got = {got[6:0], sdo};
      sck_in = 1'b1;
      wait_n(6);
      sck_in = 1'b0;
    end
    wait_n(10);
    chk("R9 slave receive", {16'd0, rx_data}, 32'h005A);
    chk("R9 slave transmit", {24'd0, got}, 32'h96);
    chk("R8 slave irq count", irq_cnt - i0, 1);
    chk("R3 slave full", {31'd0, rx_full}, 1);
    @(negedge clk);
    ss_n = 1'b1;
    wait_n(2);

    summary();
    $finish;
  end
endmodule